// File: doc/BRIEF.md
# Register Rename Status Table

This block holds a small floating-point register file together with one producer-tag field per register. The tag says which reservation station will write that register next; a tag of zero means no write is outstanding and the stored value is current. Instructions are presented one per cycle, in program order, on a single issue interface. Each instruction carries two source register numbers, one destination register number and the tag of the station that received it.

For each source, the table answers in the same cycle. It returns either the stored value with tag zero, or the pending producer's tag with a value of zero. On the clock edge it records the issuing tag as the new producer of the destination, so any earlier pending producer for that register is superseded. Completed results arrive out of order on a broadcast bus as a tag and a data word. A register takes the broadcast data, and goes back to blank, only when its recorded producer equals the broadcast tag. A superseded result therefore never reaches the register, which is how the table removes write-after-write and write-after-read hazards.

Top module: `rename_status_table`

## Requirements
- R1: A source lookup of a register whose tag is zero returns that register's stored value with tag zero, combinationally in the same cycle.
- R2: A source lookup of a register whose tag is nonzero, and whose producer is not broadcasting in that cycle, returns that tag with a value of zero.
- R3: On a clock edge where issue valid is high and the issue tag is nonzero, the destination register's tag becomes the issue tag, even if an older producer is still pending. With issue valid low, or with issue tag zero, no register's tag is changed.
- R4: A broadcast whose tag equals a register's nonzero tag writes the broadcast data into that register and sets its tag to zero, visible from the next cycle.
- R5: A broadcast whose tag differs from a register's tag leaves that register's value and tag unchanged, so a superseded producer never updates the register.
- R6: When an issue and a matching broadcast target the same register in one cycle, the register's tag becomes the new issue tag.
- R7: A source lookup whose register tag equals the tag being broadcast in that cycle returns the broadcast data with tag zero.
- R8: After reset every register reads as value zero with tag zero.
- R9: A source lookup naming the issuing instruction's own destination sees the table as it stood before that issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | RAW | First source register number |
| iss_src_b | input | RAW | Second source register number |
| iss_dst | input | RAW | Destination register number |
| iss_tag | input | TW | Station tag of the issuing instruction (zero is reserved) |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | TW | Tag of the station producing the broadcast result |
| bc_data | input | DW | Broadcast result value |
| src_a_val | output | DW | Value for the first source (zero when pending) |
| src_a_tag | output | TW | Producer tag for the first source (zero when ready) |
| src_b_val | output | DW | Value for the second source (zero when pending) |
| src_b_tag | output | TW | Producer tag for the second source (zero when ready) |

## Verification
A sweep issues every tag to every register while an arithmetic sequence of broadcast tags runs alongside. A reference table in the bench predicts every lookup in that sweep, so it separates ready reads, pending reads and same-cycle forwarding. Directed sequences issue two producers to one register and then broadcast the older one; this shows whether the tag compare blocks a stale write. Other sequences pair an issue with a matching broadcast on the same register, and read a register in the same cycle that it is renamed. A third set issues with valid low, or with tag zero, to show that no status changes.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  // Classification of one source lookup
  typedef enum logic [1:0] {
    SRC_READY   = 2'd0,
    SRC_PENDING = 2'd1,
    SRC_FORWARD = 2'd2
  } src_kind_e;
endpackage

// File: rtl/rrs_entry.sv
module rrs_entry #(
  parameter int unsigned DW  = 16,
  parameter int unsigned TW  = 3,
  parameter int unsigned RAW = 3,
  parameter int unsigned IDX = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [RAW-1:0] iss_dst,
  input  logic [TW-1:0]  iss_tag,
  input  logic           bc_valid,
  input  logic [TW-1:0]  bc_tag,
  input  logic [DW-1:0]  bc_data,
  output logic [TW-1:0]  tag_q,
  output logic [DW-1:0]  val_q
);
  localparam logic [RAW-1:0] MY_IDX = RAW'(IDX);

  logic          claim;
  logic          retire;
  logic [TW-1:0] tag_d;
  logic [DW-1:0] val_d;
  logic          tag_en;
  logic          val_en;

  always_comb begin
    claim  = iss_valid && (iss_tag != '0) && (iss_dst == MY_IDX);
    retire = bc_valid && (tag_q != '0) && (tag_q == bc_tag);
    tag_en = claim || retire;
    val_en = retire;
    tag_d  = claim ? iss_tag : '0;
    val_d  = bc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else begin
      if (tag_en) tag_q <= tag_d;
      if (val_en) val_q <= val_d;
    end
  end

  assert_issue_records_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag != '0 && iss_dst == MY_IDX) |=> (tag_q == $past(iss_tag)));

  assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iss_valid && iss_tag != '0 && iss_dst == MY_IDX) && !(bc_valid && bc_tag == tag_q))
      |=> $stable(tag_q));

  assert_match_retires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && tag_q != '0 && bc_tag == tag_q && !(iss_valid && iss_tag != '0 && iss_dst == MY_IDX))
      |=> (tag_q == '0 && val_q == $past(bc_data)));

  assert_stale_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc_valid || bc_tag != tag_q || tag_q == '0) |=> $stable(val_q));
endmodule

// File: rtl/rrs_lookup.sv
module rrs_lookup
  import rrs_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 16,
  parameter int unsigned TW   = 3,
  parameter int unsigned RAW  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [RAW-1:0]            sel,
  input  logic [NREG-1:0][TW-1:0]   tags,
  input  logic [NREG-1:0][DW-1:0]   vals,
  input  logic                      bc_valid,
  input  logic [TW-1:0]             bc_tag,
  input  logic [DW-1:0]             bc_data,
  output logic [DW-1:0]             out_val,
  output logic [TW-1:0]             out_tag
);
  logic [TW-1:0] cur_tag;
  logic [DW-1:0] cur_val;
  src_kind_e     kind;

  always_comb begin
    cur_tag = tags[sel];
    cur_val = vals[sel];
    if (cur_tag == '0)
      kind = SRC_READY;
    else if (bc_valid && bc_tag == cur_tag)
      kind = SRC_FORWARD;
    else
      kind = SRC_PENDING;
  end

  always_comb begin
    unique case (kind)
      SRC_READY:   begin out_val = cur_val; out_tag = '0;      end
      SRC_FORWARD: begin out_val = bc_data; out_tag = '0;      end
      default:     begin out_val = '0;      out_tag = cur_tag; end
    endcase
  end

  assert_pending_hides_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != '0) |-> (out_val == '0 && out_tag == tags[sel]));

  assert_forward_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0 && tags[sel] == bc_tag) |-> (out_tag == '0 && out_val == bc_data));

  assert_ready_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tags[sel] == '0) |-> (out_tag == '0 && out_val == vals[sel]));
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 16,
  parameter int unsigned TW   = 3,
  localparam int unsigned RAW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [RAW-1:0] iss_src_a,
  input  logic [RAW-1:0] iss_src_b,
  input  logic [RAW-1:0] iss_dst,
  input  logic [TW-1:0]  iss_tag,
  input  logic           bc_valid,
  input  logic [TW-1:0]  bc_tag,
  input  logic [DW-1:0]  bc_data,
  output logic [DW-1:0]  src_a_val,
  output logic [TW-1:0]  src_a_tag,
  output logic [DW-1:0]  src_b_val,
  output logic [TW-1:0]  src_b_tag
);
  logic [NREG-1:0][TW-1:0] tag_arr;
  logic [NREG-1:0][DW-1:0] val_arr;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    rrs_entry #(.DW(DW), .TW(TW), .RAW(RAW), .IDX(g)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .iss_tag   (iss_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .tag_q     (tag_arr[g]),
      .val_q     (val_arr[g])
    );
  end

  rrs_lookup #(.NREG(NREG), .DW(DW), .TW(TW), .RAW(RAW)) u_look_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (iss_src_a),
    .tags     (tag_arr),
    .vals     (val_arr),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_val  (src_a_val),
    .out_tag  (src_a_tag)
  );

  rrs_lookup #(.NREG(NREG), .DW(DW), .TW(TW), .RAW(RAW)) u_look_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (iss_src_b),
    .tags     (tag_arr),
    .vals     (val_arr),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_val  (src_b_val),
    .out_tag  (src_b_tag)
  );

  assert_newest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag != '0 && bc_valid && bc_tag == tag_arr[iss_dst])
      |=> (tag_arr[$past(iss_dst)] == $past(iss_tag)));
endmodule

// File: tb/rename_status_table_test.sv
module rename_status_table_test;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int TW   = 3;
  localparam int RAW  = 3;

  logic           clk;
  logic           rst_n;
  logic           iss_valid;
  logic [RAW-1:0] iss_src_a, iss_src_b, iss_dst;
  logic [TW-1:0]  iss_tag;
  logic           bc_valid;
  logic [TW-1:0]  bc_tag;
  logic [DW-1:0]  bc_data;
  logic [DW-1:0]  src_a_val, src_b_val;
  logic [TW-1:0]  src_a_tag, src_b_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench-side expectation of every register
  logic [TW-1:0] m_tag [NREG];
  logic [DW-1:0] m_val [NREG];

  rename_status_table #(.NREG(NREG), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src_a_val(src_a_val), .src_a_tag(src_a_tag),
    .src_b_val(src_b_val), .src_b_tag(src_b_tag)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic expect_src(input string ctx, input int sel,
                            input logic [DW-1:0] act_v, input logic [TW-1:0] act_t);
    logic [DW-1:0] ev;
    logic [TW-1:0] et;
    string cls;
    if (m_tag[sel] == '0) begin
      ev = m_val[sel]; et = '0; cls = "R1";
    end else if (bc_valid && bc_tag == m_tag[sel]) begin
      ev = bc_data; et = '0; cls = "R7";
    end else begin
      ev = '0; et = m_tag[sel]; cls = "R2";
    end
    checks++;
    if (act_v !== ev || act_t !== et) begin
      errors++;
      $display("FAIL %s/%s reg %0d: got val %h tag %0d, expected val %h tag %0d",
               ctx, cls, sel, act_v, act_t, ev, et);
    end
  endtask

  // drive one cycle, check both lookups, then advance the expectation
  task automatic step(input string ctx, input bit iv, input int sa, input int sb,
                      input int dst, input int tg, input bit bv, input int bt,
                      input int bd);
    iss_valid = iv; iss_src_a = RAW'(sa); iss_src_b = RAW'(sb);
    iss_dst = RAW'(dst); iss_tag = TW'(tg);
    bc_valid = bv; bc_tag = TW'(bt); bc_data = DW'(bd);
    #1;
    expect_src(ctx, sa, src_a_val, src_a_tag);
    expect_src(ctx, sb, src_b_val, src_b_tag);
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      if (bv && m_tag[r] != '0 && m_tag[r] == TW'(bt)) begin
        m_val[r] = DW'(bd);
        m_tag[r] = '0;
      end
      if (iv && tg != 0 && dst == r) m_tag[r] = TW'(tg);
    end
    @(negedge clk);
  endtask

  task automatic read(input string ctx, input int sa, input int sb);
    step(ctx, 1'b0, sa, sb, 0, 0, 1'b0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    iss_valid = 0; iss_src_a = '0; iss_src_b = '0; iss_dst = '0; iss_tag = '0;
    bc_valid = 0; bc_tag = '0; bc_data = '0;
    for (int r = 0; r < NREG; r++) begin m_tag[r] = '0; m_val[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: reset leaves every register blank and zero
    for (int r = 0; r < NREG; r++) read("R8", r, NREG - 1 - r);

    // R3 / R9: claim every register; source A names the destination itself
    for (int r = 0; r < NREG; r++)
      step("R9", 1'b1, r, (r + NREG - 1) % NREG, r, (r % 7) + 1, 1'b0, 0, 0);
    for (int r = 0; r < NREG; r++) read("R3", r, r);

    // R4 / R7: broadcast each tag while reading its register
    for (int t = 1; t < 8; t++)
      step("R7", 1'b0, t - 1, t % NREG, 0, 0, 1'b1, t, 16'h100 * t + 3);
    for (int r = 0; r < NREG; r++) read("R4", r, r);

    // R5: two producers for one register, older broadcast is stale
    step("R3", 1'b1, 2, 2, 2, 4, 1'b0, 0, 0);
    step("R3", 1'b1, 2, 2, 2, 5, 1'b0, 0, 0);
    step("R5", 1'b0, 2, 3, 0, 0, 1'b1, 4, 16'hDEAD);
    read("R5", 2, 2);
    step("R4", 1'b0, 1, 2, 0, 0, 1'b1, 5, 16'h5A5A);
    read("R4", 2, 2);

    // R6: issue and matching broadcast hit the same register together
    step("R3", 1'b1, 5, 5, 5, 6, 1'b0, 0, 0);
    step("R6", 1'b1, 5, 4, 5, 3, 1'b1, 6, 16'h6161);
    read("R6", 5, 5);
    step("R4", 1'b0, 5, 0, 0, 0, 1'b1, 3, 16'h3333);
    read("R4", 5, 5);

    // R3: issue with valid low, then with tag zero, changes nothing
    step("R3", 1'b0, 1, 1, 1, 2, 1'b0, 0, 0);
    read("R3", 1, 1);
    step("R3", 1'b1, 1, 1, 1, 0, 1'b0, 0, 0);
    read("R3", 1, 1);

    // sweep: every destination with every tag, broadcasts interleaved
    for (int d = 0; d < NREG; d++)
      for (int t = 1; t < 8; t++)
        step("R1", 1'b1, (d + t) % NREG, (d * 3 + t) % NREG, d, t,
             ((d + t) % 3) != 0, (d * 5 + t * 3) % 8, d * 977 + t * 131);
    for (int t = 1; t < 8; t++)
      step("R4", 1'b0, t % NREG, (t * 5) % NREG, 0, 0, 1'b1, t, t * 4099);
    for (int r = 0; r < NREG; r++) read("R4", r, (r + 4) % NREG);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule